// File: doc/BRIEF.md
# Input Gain Controller with Recovery Ceiling

This block owns the 7-bit gain code of an input amplifier. The code is linear at 0.5 dB per step: code 00H is the lowest gain and code 10H is 0 dB. Two sources update the live code. A host register port writes it directly while automatic level control is off. A recovery engine raises it in programmable steps while automatic level control is on. Each recovery step stops at a programmable ceiling and never goes past it.

The host port is a single-cycle write strobe with an address and a data word. It has a combinational readback selected by the same address. Address 0 holds the gain code and address 1 holds the recovery ceiling. Reading address 0 returns the code the host last wrote, not the live gain. An external detector supplies two signals: a tick strobe that paces recovery, and a flag that marks the input level as too high. Dropping the power-enable input forces the live gain back to 0 dB, and recovery restarts from there once power-enable returns.

Top module: `input_gain_ctl`

## Requirements
- R1: After reset, gain_o is 10H, a read of address 0 returns 10H and a read of address 1 returns 36H.
- R2: In the cycle after any cycle with pwr_en_i=0, gain_o is 10H, and host gain writes made during that time do not move it. When pwr_en_i returns to 1, the gain starts from 10H.
- R3: A write to address 0 with pwr_en_i=1 and alc_en_i=0 sets gain_o to wdata_i[6:0] on the next cycle.
- R4: A write to address 0 while alc_en_i=1 leaves gain_o unchanged.
- R5: A read of address 0 returns {0, last written wdata_i[6:0]}, even when the live gain differs from it.
- R6: A write to address 1 stores the ceiling as written when the value is 47H or less, and stores 47H when the value is larger. A read of address 1 returns the stored ceiling with bit 7 at 0.
- R7: A recovery step fires on a cycle with tick_i=1, pwr_en_i=1, alc_en_i=1 and over_lvl_i=0. On the next cycle the gain becomes min(gain+S, ceiling), where step_sel_i codes 0, 1, 2 and 3 give S = 1, 2, 4 and 8.
- R8: A recovery step leaves a gain that is already at or above the ceiling unchanged. A step never lowers the gain.
- R9: With pwr_en_i=1 and no host load, gain_o stays unchanged on any cycle where tick_i=0 or over_lvl_i=1.
- R10: When alc_en_i falls from 1 to 0, gain_o keeps the last value the recovery engine set.
- R11: Addresses 2 and 3 read as 0, and writes to them have no effect on either register or on gain_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 2 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Readback of the addressed register |
| pwr_en_i | input | 1 | Amplifier power enable |
| alc_en_i | input | 1 | Automatic level control enable |
| step_sel_i | input | 2 | Recovery step size select |
| tick_i | input | 1 | Recovery tick strobe |
| over_lvl_i | input | 1 | Input level exceeded flag |
| gain_o | output | 7 | Live gain code |

## Verification
The assertions check four things on every cycle: the forced 0 dB value after power-down, that the gain never falls while recovery is active, that a step never lands above the ceiling it began with, and that the gain holds when no source acts. The stored ceiling is also checked on every cycle against its 47H limit. Only the bench scenarios can show the exact step arithmetic across ceilings, starting gains and step sizes. The same holds for the split between the readback and the live gain, for the hold when level control is switched off, and for writes that are ignored at unused addresses or while level control is on.

// File: rtl/gain_ctl_pkg.sv
package gain_ctl_pkg;
  localparam int unsigned GAIN_W  = 7;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SSEL_W  = 2;

  localparam logic [GAIN_W-1:0] GAIN_DEF = 7'h10;
  localparam logic [GAIN_W-1:0] CEIL_DEF = 7'h36;
  localparam logic [GAIN_W-1:0] CEIL_MAX = 7'h47;

  typedef enum logic [ADDR_W-1:0] {
    REG_GAIN = 2'd0,
    REG_CEIL = 2'd1
  } reg_addr_e;
endpackage

// File: rtl/gain_regfile.sv
module gain_regfile
  import gain_ctl_pkg::*;
#(
  parameter int unsigned GW = GAIN_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter logic [GW-1:0] G_DEF = GAIN_DEF,
  parameter logic [GW-1:0] C_DEF = CEIL_DEF,
  parameter logic [GW-1:0] C_MAX = CEIL_MAX
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [GW-1:0] ceil_o,
  output logic          gain_ld_o,
  output logic [GW-1:0] gain_val_o
);
  localparam logic [DW-1:0] CMAX_EXT = DW'(C_MAX);

  logic [GW-1:0] shadow_q, ceil_q;
  logic          wr_gain, wr_ceil;
  logic [GW-1:0] ceil_in;

  assign wr_gain = wr_en_i && (addr_i == AW'(REG_GAIN));
  assign wr_ceil = wr_en_i && (addr_i == AW'(REG_CEIL));
  // clamp oversize ceiling writes to top of valid range
  assign ceil_in = (wdata_i > CMAX_EXT) ? C_MAX : wdata_i[GW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= G_DEF;
      ceil_q   <= C_DEF;
    end else begin
      if (wr_gain) shadow_q <= wdata_i[GW-1:0];
      if (wr_ceil) ceil_q   <= ceil_in;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(REG_GAIN): rdata_o = DW'(shadow_q);
      AW'(REG_CEIL): rdata_o = DW'(ceil_q);
      default:       rdata_o = '0;
    endcase
  end

  assign ceil_o     = ceil_q;
  assign gain_ld_o  = wr_gain;
  assign gain_val_o = wdata_i[GW-1:0];
endmodule

// File: rtl/gain_recovery_step.sv
module gain_recovery_step
  import gain_ctl_pkg::*;
#(
  parameter int unsigned GW = GAIN_W,
  parameter int unsigned SW = SSEL_W
) (
  input  logic [GW-1:0] gain_i,
  input  logic [GW-1:0] ceil_i,
  input  logic [SW-1:0] step_sel_i,
  output logic [GW-1:0] next_o
);
  localparam int unsigned XW = GW + 1;

  logic [XW-1:0] step_amt, sum;

  assign step_amt = XW'(1) << step_sel_i;
  assign sum      = XW'(gain_i) + step_amt;

  always_comb begin
    if (gain_i >= ceil_i)          next_o = gain_i;
    else if (sum > XW'(ceil_i))    next_o = ceil_i;
    else                           next_o = sum[GW-1:0];
  end
endmodule

// File: rtl/gain_live_reg.sv
module gain_live_reg
  import gain_ctl_pkg::*;
#(
  parameter int unsigned GW = GAIN_W,
  parameter logic [GW-1:0] G_DEF = GAIN_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_en_i,
  input  logic          alc_en_i,
  input  logic          host_ld_i,
  input  logic [GW-1:0] host_val_i,
  input  logic          rec_fire_i,
  input  logic [GW-1:0] rec_val_i,
  output logic [GW-1:0] gain_o
);
  logic [GW-1:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      gain_q <= G_DEF;
    else if (!pwr_en_i)               gain_q <= G_DEF;
    else if (host_ld_i && !alc_en_i)  gain_q <= host_val_i;
    else if (rec_fire_i && alc_en_i)  gain_q <= rec_val_i;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/input_gain_ctl.sv
module input_gain_ctl
  import gain_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pwr_en_i,
  input  logic              alc_en_i,
  input  logic [SSEL_W-1:0] step_sel_i,
  input  logic              tick_i,
  input  logic              over_lvl_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] ceil_w, host_val_w, rec_val_w;
  logic              host_ld_w, rec_fire_w;

  gain_regfile i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .ceil_o     (ceil_w),
    .gain_ld_o  (host_ld_w),
    .gain_val_o (host_val_w)
  );

  gain_recovery_step i_step (
    .gain_i     (gain_o),
    .ceil_i     (ceil_w),
    .step_sel_i (step_sel_i),
    .next_o     (rec_val_w)
  );

  assign rec_fire_w = tick_i && !over_lvl_i;

  gain_live_reg i_live (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_en_i   (pwr_en_i),
    .alc_en_i   (alc_en_i),
    .host_ld_i  (host_ld_w),
    .host_val_i (host_val_w),
    .rec_fire_i (rec_fire_w),
    .rec_val_i  (rec_val_w),
    .gain_o     (gain_o)
  );
endmodule

// File: rtl/gain_ctl_chk.sv
module gain_ctl_chk
  import gain_ctl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              pwr_en_i,
  input logic              alc_en_i,
  input logic              tick_i,
  input logic              over_lvl_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic [GAIN_W-1:0] ceil_q
);
  // R2
  pwr_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> gain_o == GAIN_DEF);

  // R8
  no_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && alc_en_i) |=> gain_o >= $past(gain_o));

  // R7
  ceil_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && alc_en_i && tick_i && !over_lvl_i && gain_o < ceil_q)
      |=> gain_o <= $past(ceil_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_i && (!tick_i || over_lvl_i) &&
     !(wr_en_i && addr_i == ADDR_W'(REG_GAIN) && !alc_en_i)) |=> $stable(gain_o));

  // R6
  ceil_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ceil_q <= CEIL_MAX);
endmodule

bind input_gain_ctl gain_ctl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .pwr_en_i   (pwr_en_i),
  .alc_en_i   (alc_en_i),
  .tick_i     (tick_i),
  .over_lvl_i (over_lvl_i),
  .gain_o     (gain_o),
  .ceil_q     (ceil_w)
);

// File: tb/test_input_gain_ctl.sv
`timescale 1ns/1ps
module test_input_gain_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwr_en = 1'b0;
  logic       alc_en = 1'b0;
  logic [1:0] step_sel = '0;
  logic       tick = 1'b0;
  logic       over_lvl = 1'b0;
  logic [6:0] gain;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  input_gain_ctl i_input_gain_ctl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwr_en_i(pwr_en), .alc_en_i(alc_en),
    .step_sel_i(step_sel), .tick_i(tick), .over_lvl_i(over_lvl), .gain_o(gain)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic int exp_step(int g, int c, int s);
    int sum;
    if (g >= c) return g;
    sum = g + (1 << s);
    return (sum > c) ? c : sum;
  endfunction

  initial begin
    logic [7:0] r;
    #2000000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int g0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 gain", gain, 'h10);
    rd(2'd0, r); chk("R1 gain readback", r, 'h10);
    rd(2'd1, r); chk("R1 ceiling readback", r, 'h36);

    // R2 write while powered down is blocked
    wr(2'd0, 8'h22);
    chk("R2 write while off", gain, 'h10);
    rd(2'd0, r); chk("R5 readback while off", r, 'h22);

    @(negedge clk); pwr_en = 1'b1;
    @(negedge clk);
    chk("R2 power up from default", gain, 'h10);

    // R3 host load
    wr(2'd0, 8'h2A);
    chk("R3 host load", gain, 'h2A);
    wr(2'd0, 8'hFF);
    chk("R3 host load masked", gain, 'h7F);
    rd(2'd0, r); chk("R5 bit7 dropped", r, 'h7F);

    // R6 ceiling clamp
    wr(2'd1, 8'h50); rd(2'd1, r); chk("R6 clamp 50", r, 'h47);
    wr(2'd1, 8'hC0); rd(2'd1, r); chk("R6 clamp C0", r, 'h47);
    wr(2'd1, 8'h47); rd(2'd1, r); chk("R6 top", r, 'h47);
    wr(2'd1, 8'h12); rd(2'd1, r); chk("R6 plain", r, 'h12);

    // R11 unused addresses
    wr(2'd2, 8'h33); wr(2'd3, 8'h05);
    rd(2'd2, r); chk("R11 read 2", r, 0);
    rd(2'd3, r); chk("R11 read 3", r, 0);
    rd(2'd0, r); chk("R11 gain reg kept", r, 'h7F);
    rd(2'd1, r); chk("R11 ceiling kept", r, 'h12);
    chk("R11 live kept", gain, 'h7F);

    // R7 R8 sweep: ceilings x start gains x step sizes
    for (int c = 0; c <= 'h47; c += 7) begin
      for (int g = 0; g < 128; g += 5) begin
        for (int s = 0; s < 4; s++) begin
          @(negedge clk); alc_en = 1'b0; step_sel = 2'(s);
          wr(2'd1, 8'(c));
          wr(2'd0, 8'(g));
          @(negedge clk); alc_en = 1'b1;
          pulse_tick();
          if (g >= c) chk("R8 at/above ceiling", gain, g);
          else        chk("R7 step", gain, exp_step(g, c, s));
        end
      end
    end

    // R7 repeated steps up to the ceiling, then R10 hold
    @(negedge clk); alc_en = 1'b0;
    wr(2'd1, 8'h30); wr(2'd0, 8'h20);
    @(negedge clk); alc_en = 1'b1; step_sel = 2'd1;
    g0 = 'h20;
    for (int k = 0; k < 10; k++) begin
      pulse_tick();
      g0 = exp_step(g0, 'h30, 1);
      chk("R7 chained step", gain, g0);
    end
    chk("R7 ceiling reached", gain, 'h30);

    // R9 over-level blocks, no tick holds
    @(negedge clk); alc_en = 1'b0; wr(2'd0, 8'h10);
    @(negedge clk); alc_en = 1'b1; over_lvl = 1'b1;
    pulse_tick();
    chk("R9 over-level blocks", gain, 'h10);
    over_lvl = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 no tick holds", gain, 'h10);

    // R4 write ignored while alc on
    pulse_tick();
    chk("R7 single step", gain, 'h12);
    wr(2'd0, 8'h05);
    chk("R4 write ignored", gain, 'h12);
    rd(2'd0, r); chk("R5 readback differs", r, 'h05);

    // R10 falling alc holds
    @(negedge clk); alc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold after alc off", gain, 'h12);

    // R2 power-down mid recovery, restart from default
    @(negedge clk); alc_en = 1'b1;
    pulse_tick();
    chk("R7 step before power-down", gain, 'h14);
    @(negedge clk); pwr_en = 1'b0;
    @(negedge clk);
    chk("R2 power-down default", gain, 'h10);
    pulse_tick();
    chk("R2 tick while off", gain, 'h10);
    @(negedge clk); pwr_en = 1'b1;
    pulse_tick();
    chk("R2 restart from default", gain, 'h12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule